// File: doc/BRIEF.md
# Serial Port Register Block

This block is the software-facing register set of a simple serial port. A processor reaches it over a 32-bit bus. The bus is split into a write port and a read port, and both are word-addressed. Writing the data-out word sends one byte on a valid/ready transmit stream. The sink on that stream is assumed to be always ready. Bytes arriving on a valid/ready receive stream are kept in a 16-entry FIFO. Two status words report the transmitter state and the oldest held byte. Reading one of them leaves the FIFO unchanged; reading the other consumes the byte.

Interrupt causes collect in a raw register. Software clears them by writing ones to an acknowledge word. A mask selects which causes reach the single interrupt line. The receive-data cause is not latched: it follows FIFO occupancy directly. All other words are plain storage. Serialization, baud timing, DMA and framing belong to other blocks.

Top module: `uart_regblock`

## Requirements
- R1: After reset, word 2 (receive control) reads 0x00010000 and every other stored word reads 0. The raw and masked interrupt words read 0, `irq_o` is low and `rx_ready_o` is low.
- R2: A write to word 7 (data out) stores the value. In the next cycle `tx_valid_o` is high for exactly one cycle and `tx_data_o` carries bits 7:0 of the written value. The write also sets bits 0 and 1 of the raw interrupt word (word 13).
- R3: A write to word 12 (acknowledge) stores the value, which reads back from word 12. It clears every raw interrupt bit that is 1 in the written value and leaves the other raw bits unchanged.
- R4: Word 14 reads raw AND mask, where the mask is word 11. `irq_o` is high exactly when that value is non-zero, starting from the cycle after the write that changed it.
- R5: Raw interrupt bit 3 is 1 whenever the receive FIFO holds at least one byte and 0 whenever it is empty. An acknowledge write does not clear it while bytes remain.
- R6: Words 8 and 9 both read with bit 24 (transmitter ready) and bit 22 (transmitter idle) set. Bit 8 is 1 when the FIFO is non-empty, and bits 7:0 hold the oldest byte.
- R7: A read of word 9 removes the oldest byte when the FIFO is non-empty and has no effect when it is empty. A read of word 8 never removes a byte.
- R8: The FIFO holds 16 bytes and returns them in arrival order, including across wrap-around of its 4-bit write pointer.
- R9: `rx_ready_o` is low when receive-control bit 3 (receiver enable) is 0 or when 16 bytes are held. A byte offered while `rx_ready_o` is low is dropped.
- R10: Words 0, 1 and the unused words below 15 read back the last value written. Word 15 lies outside the decoded space: it reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 4 | Write word address |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe (needed for the word-9 pop) |
| rd_addr_i | input | 4 | Read word address |
| rd_data_o | output | 32 | Read data, combinational from `rd_addr_i` |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_ready_o | output | 1 | Receive byte accepted when high with `rx_valid_i` |
| irq_o | output | 1 | Interrupt line |

## Verification
The checker tests several rules on every cycle:
- a data-out write is followed by a transmit strobe carrying its low byte;
- raw bit 3 matches FIFO occupancy;
- input ready is held low when the receiver is disabled or the FIFO is full;
- the FIFO count only falls on a pop read;
- the interrupt line never rises while the mask is zero.

Arrival order, wrap-around of the pointers, the stored values read back, and the acknowledge semantics can only be shown by the bench's directed scenarios. The same holds for the difference between the peek word and the pop word.

// File: rtl/uart_regblock_pkg.sv
package uart_regblock_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned NUM_WORDS = 15;  // word 15 and above undecoded

  localparam logic [ADDR_W-1:0] W_RX_CTRL   = 4'd2;
  localparam logic [ADDR_W-1:0] W_DOUT      = 4'd7;
  localparam logic [ADDR_W-1:0] W_STAT_PEEK = 4'd8;
  localparam logic [ADDR_W-1:0] W_STAT_POP  = 4'd9;
  localparam logic [ADDR_W-1:0] W_IRQ_MASK  = 4'd11;
  localparam logic [ADDR_W-1:0] W_IRQ_ACK   = 4'd12;
  localparam logic [ADDR_W-1:0] W_IRQ_RAW   = 4'd13;
  localparam logic [ADDR_W-1:0] W_IRQ_MSKD  = 4'd14;

  localparam int unsigned TX_RDY_BIT  = 24;
  localparam int unsigned TX_IDLE_BIT = 22;
  localparam int unsigned AVAIL_BIT   = 8;
  localparam int unsigned RX_EN_BIT   = 3;
  localparam int unsigned IRQ_RX_BIT  = 3;

  localparam logic [DATA_W-1:0] RX_CTRL_RST = 32'h0001_0000;
  localparam logic [DATA_W-1:0] TX_IRQ_SET  = 32'h0000_0003;
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q;
  logic [CW-1:0] count_q;
  logic [PW-1:0] rd_idx;
  logic          do_push, do_pop;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  // read position derived from write pointer and occupancy
  assign rd_idx  = wr_ptr_q - count_q[PW-1:0];
  assign head_o  = mem_q[rd_idx];
  assign count_o = count_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_mem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[g] <= '0;
      else if (do_push && wr_ptr_q == PW'(g))     mem_q[g] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/uart_reg_store.sv
module uart_reg_store
  import uart_regblock_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NW = NUM_WORDS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [DW-1:0]        wr_data_i,
  output logic [NW-1:0][DW-1:0] regs_o
);
  for (genvar g = 0; g < NW; g++) begin : g_word
    localparam logic [DW-1:0] RST_VAL = (AW'(g) == W_RX_CTRL) ? RX_CTRL_RST : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_o[g] <= RST_VAL;
      else if (wr_en_i && wr_addr_i == AW'(g))  regs_o[g] <= wr_data_i;
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_regblock_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_fire_i,
  input  logic          ack_fire_i,
  input  logic          raw_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rx_avail_i,
  input  logic [DW-1:0] mask_i,
  output logic [DW-1:0] raw_o,
  output logic [DW-1:0] masked_o,
  output logic          irq_o
);
  logic [DW-1:0] raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         raw_q <= '0;
    else if (tx_fire_i)  raw_q <= raw_q | DW'(TX_IRQ_SET);
    else if (ack_fire_i) raw_q <= raw_q & ~wdata_i;
    else if (raw_wr_i)   raw_q <= wdata_i;
  end

  // receive cause follows occupancy, never latched
  always_comb begin
    raw_o             = raw_q;
    raw_o[IRQ_RX_BIT] = rx_avail_i;
  end
  assign masked_o = raw_o & mask_i;
  assign irq_o    = |masked_o;
endmodule

// File: rtl/uart_regblock.sv
module uart_regblock
  import uart_regblock_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  output logic              irq_o
);
  logic [NUM_WORDS-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0] raw, masked, status;
  logic [7:0]        fifo_head;
  logic [CW-1:0]     fifo_count;
  logic              fifo_full, fifo_empty, rx_en, pop, push;
  logic              tx_fire, ack_fire, raw_wr;

  assign tx_fire  = wr_en_i && wr_addr_i == W_DOUT;
  assign ack_fire = wr_en_i && wr_addr_i == W_IRQ_ACK;
  assign raw_wr   = wr_en_i && wr_addr_i == W_IRQ_RAW;
  assign rx_en    = regs[W_RX_CTRL][RX_EN_BIT];
  assign rx_ready_o = rx_en && !fifo_full;
  assign push     = rx_valid_i && rx_ready_o;
  assign pop      = rd_en_i && rd_addr_i == W_STAT_POP;

  uart_reg_store u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .regs_o(regs)
  );

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .data_i(rx_data_i), .pop_i(pop),
    .head_o(fifo_head), .count_o(fifo_count),
    .full_o(fifo_full), .empty_o(fifo_empty)
  );

  uart_irq_ctrl u_irq (
    .clk_i, .rst_ni,
    .tx_fire_i(tx_fire), .ack_fire_i(ack_fire), .raw_wr_i(raw_wr),
    .wdata_i(wr_data_i), .rx_avail_i(!fifo_empty),
    .mask_i(regs[W_IRQ_MASK]), .raw_o(raw), .masked_o(masked), .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      tx_valid_o <= tx_fire;
      if (tx_fire) tx_data_o <= wr_data_i[7:0];
    end
  end

  always_comb begin
    status              = '0;
    status[TX_RDY_BIT]  = 1'b1;
    status[TX_IDLE_BIT] = 1'b1;
    status[AVAIL_BIT]   = !fifo_empty;
    status[7:0]         = fifo_head;
  end

  always_comb begin
    unique case (rd_addr_i)
      W_STAT_PEEK, W_STAT_POP: rd_data_o = status;
      W_IRQ_RAW:               rd_data_o = raw;
      W_IRQ_MSKD:              rd_data_o = masked;
      default: rd_data_o = (int'(rd_addr_i) < NUM_WORDS) ?
                           regs[rd_addr_i[3:0]] : '0;
    endcase
  end
endmodule

// File: rtl/uart_regblock_chk.sv
module uart_regblock_chk
  import uart_regblock_pkg::*;
#(
  parameter int unsigned CW = 5,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              tx_valid_o,
  input logic [7:0]        tx_data_o,
  input logic              rx_ready_o,
  input logic              irq_o,
  input logic [CW-1:0]     fifo_count,
  input logic [DATA_W-1:0] raw,
  input logic [DATA_W-1:0] mask,
  input logic              rx_en
);
  assert_tx_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == W_DOUT) |=> (tx_valid_o && tx_data_o == $past(wr_data_i[7:0])));

  assert_tx_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == W_DOUT) |=> !tx_valid_o);

  assert_rx_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw[IRQ_RX_BIT] == (fifo_count != '0));

  assert_ready_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en || fifo_count == CW'(FIFO_DEPTH)) |-> !rx_ready_o);

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_count <= CW'(FIFO_DEPTH));

  assert_only_pop_drains_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && rd_addr_i == W_STAT_POP) |=> fifo_count >= $past(fifo_count));

  assert_irq_needs_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> mask != '0);
endmodule

bind uart_regblock uart_regblock_chk #(.CW(CW), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_en_i, .rd_addr_i,
  .tx_valid_o, .tx_data_o, .rx_ready_o, .irq_o,
  .fifo_count(fifo_count), .raw(raw), .mask(regs[11]), .rx_en(rx_en)
);

// File: tb/uart_regblock_tb.sv
`timescale 1ns/1ps
module uart_regblock_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, rx_valid = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [7:0]  rx_data = '0, tx_data;
  logic        tx_valid, rx_ready, irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  uart_regblock u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, bit en, output logic [31:0] d);
    @(negedge clk); rd_en = en; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic push(logic [7:0] b, output bit took);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    #1 took = rx_ready;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  localparam logic [31:0] ST = 32'h0140_0000;

  task automatic t_reset();
    logic [31:0] d;
    rd(4'd2, 0, d);  chk("R1 rxctrl", d, 32'h0001_0000);
    rd(4'd11, 0, d); chk("R1 mask", d, 0);
    rd(4'd13, 0, d); chk("R1 raw", d, 0);
    rd(4'd8, 0, d);  chk("R6 empty status", d, ST);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 0);
  endtask

  task automatic t_rx_disabled();
    bit took; logic [31:0] d;
    push(8'h5A, took); chk("R9 disabled ready", {31'b0, took}, 0);
    rd(4'd8, 0, d);    chk("R9 dropped byte", d, ST);
  endtask

  task automatic t_tx_irq();
    logic [31:0] d;
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'd7; wr_data = 32'hABCD_1234;
    @(negedge clk); wr_en = 1'b0;
    chk("R2 tx_valid", {31'b0, tx_valid}, 1);
    chk("R2 tx_data", {24'b0, tx_data}, 32'h34);
    @(negedge clk);
    chk("R2 tx_valid single", {31'b0, tx_valid}, 0);
    rd(4'd7, 0, d);  chk("R2 dout stored", d, 32'hABCD_1234);
    rd(4'd13, 0, d); chk("R2 raw set", d, 32'h3);
    chk("R4 irq masked off", {31'b0, irq}, 0);
    wr(4'd11, 32'h2);
    chk("R4 irq on", {31'b0, irq}, 1);
    rd(4'd14, 0, d); chk("R4 masked", d, 32'h2);
    wr(4'd12, 32'h2);
    rd(4'd13, 0, d); chk("R3 ack clears", d, 32'h1);
    rd(4'd12, 0, d); chk("R3 ack stored", d, 32'h2);
    chk("R4 irq off", {31'b0, irq}, 0);
  endtask

  task automatic t_rx_basic();
    bit took; logic [31:0] d;
    wr(4'd2, 32'h0001_0008);
    push(8'h11, took); chk("R9 enabled ready", {31'b0, took}, 1);
    push(8'h22, took);
    rd(4'd8, 1, d); chk("R6 peek", d, ST | 32'h111);
    rd(4'd8, 1, d); chk("R7 peek no pop", d, ST | 32'h111);
    rd(4'd13, 0, d); chk("R5 raw rx bit", d, 32'h9);
    wr(4'd11, 32'h8);
    chk("R4 irq rx", {31'b0, irq}, 1);
    wr(4'd12, 32'h8);
    rd(4'd13, 0, d); chk("R5 ack keeps rx", d, 32'h9);
    rd(4'd9, 1, d); chk("R7 pop first", d, ST | 32'h111);
    rd(4'd9, 1, d); chk("R7 pop second", d, ST | 32'h122);
    rd(4'd13, 0, d); chk("R5 raw empty", d, 32'h1);
    chk("R5 irq empty", {31'b0, irq}, 0);
    rd(4'd9, 1, d); chk("R7 pop empty flag", d & 32'hFFFF_FF00, ST);
    push(8'h33, took);
    rd(4'd8, 0, d); chk("R7 empty pop harmless", d, ST | 32'h133);
    rd(4'd9, 1, d);
  endtask

  task automatic t_fill();
    bit took; logic [31:0] d;
    for (int i = 0; i < 16; i++) begin
      push(8'hA0 + 8'(i), took);
      chk("R8 accept", {31'b0, took}, 1);
    end
    push(8'hEE, took); chk("R9 full ready", {31'b0, took}, 0);
    for (int i = 0; i < 16; i++) begin
      rd(4'd9, 1, d); chk("R8 order", d, ST | 32'h100 | 32'(8'hA0 + 8'(i)));
    end
    rd(4'd8, 0, d); chk("R8 drained", d & 32'hFFFF_FF00, ST);
  endtask

  task automatic t_plain();
    logic [31:0] d;
    wr(4'd1, 32'hDEAD_BEEF);
    rd(4'd1, 0, d);  chk("R10 word1", d, 32'hDEAD_BEEF);
    wr(4'd0, 32'h0000_5A5A);
    rd(4'd0, 0, d);  chk("R10 word0", d, 32'h0000_5A5A);
    wr(4'd4, 32'h1234_5678);
    rd(4'd4, 0, d);  chk("R10 word4", d, 32'h1234_5678);
    wr(4'd15, 32'hFFFF_FFFF);
    rd(4'd15, 0, d); chk("R10 word15", d, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rx_disabled();
    t_tx_irq();
    t_rx_basic();
    t_fill();
    t_plain();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule